// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block sits between a transmitter and the host and keeps one status record for each finished frame. The transmitter signals a completion with a one-cycle event and a set of flags. The block stores the record in a four-entry first-in first-out stack. The host reads the oldest record as a single byte. Reading leaves the record in place, and the host moves on to the next record by writing to the status location. When a completion arrives and the stack has no room, the record is lost. The newest stored record is then marked so the host learns that something was dropped.

Two transmit faults stop the transmitter until software acts: a jabber error and a data underrun. Either one sets a lock output that holds the transmitter off. Only a transmit reset releases it, and that reset also empties the stack. An interrupt request stays high while any stored record reports an error or asks for a completion interrupt.

Top module: `txstat_stack`

## Requirements
- R1: One cycle after `host_rd` is sampled, `rd_data` holds the oldest record with this layout: bit 7 = 1 (complete), bit 6 = success interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = records lost, bits 1:0 = 0. `rd_data` keeps its value until the next read.
- R2: A host read never removes a record; reading again returns the same byte.
- R3: A `host_wr` removes the oldest record. A `host_wr` on an empty stack has no effect.
- R4: The stack holds up to 4 records and returns them in arrival order.
- R5: A read of an empty stack returns 8'h00.
- R6: A completion that arrives when 4 records are stored and no pop happens in the same cycle is discarded, and bit 2 of the newest stored record is set.
- R7: A completion and a `host_wr` in the same cycle on a full stack pop the oldest record and store the new one, so no record is lost.
- R8: `tx_int` is high exactly while at least one stored record has any of bits 6..2 set.
- R9: A completion with jabber or underrun set raises `tx_disable` on the next cycle, even when its record is discarded. `tx_disable` then stays high until `tx_reset`.
- R10: `tx_reset` empties the stack and clears `tx_disable`, and it overrides any completion or pop in the same cycle.
- R11: After `rst_n` the stack is empty and `rd_data`, `tx_int` and `tx_disable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_reset | input | 1 | Transmit reset: empties stack and releases the lock |
| cmpl_valid | input | 1 | One-cycle frame completion event |
| cmpl_int_req | input | 1 | Frame asked for an interrupt on success |
| cmpl_jabber | input | 1 | Jabber fault on the frame |
| cmpl_underrun | input | 1 | Data underrun on the frame |
| cmpl_maxcoll | input | 1 | Frame hit the collision limit |
| host_rd | input | 1 | Host read strobe for the status byte |
| host_wr | input | 1 | Host write strobe: pop the oldest record |
| rd_data | output | 8 | Status byte captured by the last read |
| tx_int | output | 1 | Transmit-complete interrupt request |
| tx_disable | output | 1 | Transmitter lock after a fatal fault |

## Verification
Each fault in the pointers or the count shows up at the next read. It appears as a byte out of order, a stale byte that repeats, or a zero where a record should be. A wrong live-slot mask shows up at once on `tx_int`, in the same cycle the bad state is registered. A lock fault shows on `tx_disable` one cycle after the fault event, or one cycle after `tx_reset`. The bench sweeps all sixteen flag combinations and runs a lossless pass and a lossy pass through the full stack. It also checks every port against its own queue model after every cycle.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  typedef struct packed {
    logic int_req;
    logic jabber;
    logic underrun;
    logic maxcoll;
    logic lost;
  } txrec_t;

  function automatic logic [7:0] status_byte(input logic present, input txrec_t r);
    return present ? {1'b1, r.int_req, r.jabber, r.underrun, r.maxcoll, r.lost, 2'b00}
                   : 8'h00;
  endfunction

  function automatic logic rec_wants_irq(input txrec_t r);
    return |r;
  endfunction

  function automatic logic rec_is_fatal(input txrec_t r);
    return r.jabber | r.underrun;
  endfunction

endpackage

// File: rtl/txstat_fifo.sv
module txstat_fifo
  import txstat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        push,
  input  txrec_t                      push_rec,
  input  logic                        pop,
  output txrec_t                      head_rec,
  output logic                        head_valid,
  output logic                        any_irq,
  output logic [$clog2(DEPTH+1)-1:0]  count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  txrec_t          mem [DEPTH];
  logic [PW-1:0]   rd_ptr, wr_ptr, tail_ptr;
  logic [CW-1:0]   count;
  logic            full, pop_eff, push_ok, push_drop;
  logic [DEPTH-1:0] slot_live, slot_irq;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign head_valid = (count != '0);
  assign pop_eff   = pop && head_valid;
  assign push_ok   = push && (!full || pop_eff);
  assign push_drop = push && full && !pop_eff;
  assign tail_ptr  = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
  assign head_rec  = mem[rd_ptr];
  assign count_o   = count;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      int off;
      off = (i + DEPTH - int'(rd_ptr)) % DEPTH;
      slot_live[i] = (off < int'(count));
      slot_irq[i]  = slot_live[i] && rec_wants_irq(mem[i]);
    end
  end

  assign any_irq = |slot_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_eff) rd_ptr <= ptr_next(rd_ptr);
      if (push_ok) begin
        mem[wr_ptr] <= push_rec;
        wr_ptr      <= ptr_next(wr_ptr);
      end
      if (push_drop) mem[tail_ptr].lost <= 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_eff);
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_drop_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !clear) |=> (count == CW'(DEPTH)));

  assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_valid && !push && !clear) |=> (count == $past(count) - 1'b1));

  assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full && !clear) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/txstat_lock.sv
module txstat_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set_evt,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b0;
    else if (clear)   locked <= 1'b0;
    else if (set_evt) locked <= 1'b1;
  end

  assert_lock_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(set_evt));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear) |=> locked);

endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
  import txstat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_reset,
  input  logic       cmpl_valid,
  input  logic       cmpl_int_req,
  input  logic       cmpl_jabber,
  input  logic       cmpl_underrun,
  input  logic       cmpl_maxcoll,
  input  logic       host_rd,
  input  logic       host_wr,
  output logic [7:0] rd_data,
  output logic       tx_int,
  output logic       tx_disable
);
  localparam int CW = $clog2(DEPTH + 1);

  txrec_t        new_rec, head_rec;
  logic          head_valid, any_irq, fatal_evt;
  logic [CW-1:0] fill_count;

  assign new_rec   = '{int_req: cmpl_int_req, jabber: cmpl_jabber,
                       underrun: cmpl_underrun, maxcoll: cmpl_maxcoll, lost: 1'b0};
  assign fatal_evt = cmpl_valid && rec_is_fatal(new_rec);

  txstat_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .clear(tx_reset),
    .push(cmpl_valid), .push_rec(new_rec), .pop(host_wr),
    .head_rec(head_rec), .head_valid(head_valid),
    .any_irq(any_irq), .count_o(fill_count)
  );

  txstat_lock lock_i (
    .clk(clk), .rst_n(rst_n), .clear(tx_reset),
    .set_evt(fatal_evt), .locked(tx_disable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= 8'h00;
    else if (host_rd) rd_data <= status_byte(head_valid, head_rec);
  end

  assign tx_int = any_irq;

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !head_valid) |=> (rd_data == 8'h00));

  assert_read_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && !cmpl_valid && !tx_reset) |=> $stable(fill_count));

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_disable && !tx_int && fill_count == '0));

  assert_complete_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && head_valid) |=> (rd_data[7] && rd_data[1:0] == 2'b00));

  assert_fatal_locks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_evt && !tx_reset) |=> tx_disable);

  assert_irq_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> !tx_int);

endmodule

// File: tb/txstat_stack_tb_top.sv
module txstat_stack_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_reset = 0, cmpl_valid = 0, cmpl_int_req = 0, cmpl_jabber = 0;
  logic cmpl_underrun = 0, cmpl_maxcoll = 0, host_rd = 0, host_wr = 0;
  logic [7:0] rd_data;
  logic tx_int, tx_disable;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] mq[$];
  logic [7:0] exp_rd = 8'h00;
  logic exp_lock = 1'b0;

  always #10 clk = ~clk;

  txstat_stack dut_i (
    .clk(clk), .rst_n(rst_n), .tx_reset(tx_reset), .cmpl_valid(cmpl_valid),
    .cmpl_int_req(cmpl_int_req), .cmpl_jabber(cmpl_jabber),
    .cmpl_underrun(cmpl_underrun), .cmpl_maxcoll(cmpl_maxcoll),
    .host_rd(host_rd), .host_wr(host_wr), .rd_data(rd_data),
    .tx_int(tx_int), .tx_disable(tx_disable)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] rec_byte(input logic [3:0] f);
    // f = {int_req, jabber, underrun, maxcoll}
    return 8'h80 | (8'(f) << 3);
  endfunction

  function automatic logic model_irq();
    foreach (mq[i]) if ((mq[i] & 8'h7C) != 0) return 1'b1;
    return 1'b0;
  endfunction

  // One cycle: drive at negedge, update model at posedge, compare 5 ns later.
  task automatic step(input string req, input logic v, input logic [3:0] f,
                      input logic rd, input logic wr, input logic trst);
    @(negedge clk);
    cmpl_valid = v; {cmpl_int_req, cmpl_jabber, cmpl_underrun, cmpl_maxcoll} = f;
    host_rd = rd; host_wr = wr; tx_reset = trst;
    @(posedge clk);
    if (rd) exp_rd = (mq.size() > 0) ? mq[0] : 8'h00;
    if (trst) begin
      mq.delete();
      exp_lock = 1'b0;
    end else begin
      if (v && (f[2] || f[1])) exp_lock = 1'b1;
      if (wr && mq.size() > 0) void'(mq.pop_front());
      if (v) begin
        if (mq.size() < 4) mq.push_back(rec_byte(f));
        else mq[mq.size()-1] = mq[mq.size()-1] | 8'h04;
      end
    end
    #5;
    check(req, "rd_data", int'(rd_data), int'(exp_rd));
    check("R8", "tx_int", int'(tx_int), int'(model_irq()));
    check("R9", "tx_disable", int'(tx_disable), int'(exp_lock));
    @(negedge clk);
    cmpl_valid = 0; host_rd = 0; host_wr = 0; tx_reset = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R11: reset state
    check("R11", "rd_data", int'(rd_data), 0);
    check("R11", "tx_int", int'(tx_int), 0);
    check("R11", "tx_disable", int'(tx_disable), 0);
    @(negedge clk); rst_n = 1'b1;

    step("R5", 0, 4'h0, 1, 0, 0);              // R5: read of empty stack

    // R1 R2 R8 R9 R10: sweep every flag combination
    for (int f = 0; f < 16; f++) begin
      step("R1", 1, 4'(f), 0, 0, 0);
      step("R1", 0, 4'h0, 1, 0, 0);
      step("R2", 0, 4'h0, 1, 0, 0);            // R2: second read, same byte
      step("R3", 0, 4'h0, 0, 1, 0);            // R3: pop
      step("R5", 0, 4'h0, 1, 0, 0);
      step("R10", 0, 4'h0, 0, 0, 1);           // R10: release lock
    end

    // R4: fill, then drain in order
    for (int k = 0; k < 4; k++) step("R4", 1, 4'(k * 5 + 1), 0, 0, 0);
    for (int k = 0; k < 4; k++) step("R4", 0, 4'h0, 1, 1, 0);
    step("R5", 0, 4'h0, 1, 0, 0);

    // R6: overfill by two, newest kept record gets lost bit
    for (int k = 0; k < 6; k++) step("R6", 1, 4'(k & 1), 0, 0, 0);
    for (int k = 0; k < 4; k++) step("R6", 0, 4'h0, 1, 1, 0);

    // R7: full stack, push and pop together
    for (int k = 0; k < 4; k++) step("R7", 1, 4'h1, 0, 0, 0);
    step("R7", 1, 4'h8, 0, 1, 0);
    for (int k = 0; k < 4; k++) step("R7", 0, 4'h0, 1, 1, 0);

    // R3: pop on empty is ignored
    step("R3", 0, 4'h0, 0, 1, 0);
    step("R3", 1, 4'h0, 0, 0, 0);
    step("R3", 0, 4'h0, 1, 0, 0);
    step("R3", 0, 4'h0, 0, 1, 0);

    // R9: fatal fault on a dropped record still locks
    for (int k = 0; k < 4; k++) step("R9", 1, 4'h0, 0, 0, 0);
    step("R9", 1, 4'h4, 0, 0, 0);
    step("R9", 0, 4'h0, 1, 0, 0);
    // R10: reset overrides a simultaneous push and pop
    step("R10", 1, 4'h2, 0, 1, 1);
    step("R10", 0, 4'h0, 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule